// File: doc/BRIEF.md
# Register Address Decoder with Error Response

This block sits behind a generic CPU-interface front end. Each cycle that front end may present one request made of a valid flag, a direction bit, a byte address and write data. The decoder matches the address against a fixed map and produces one strobe per target. The map holds a read/write control word, a constant identity word that software may only read, a command word that software may only write, a wide register split into access-width subwords, and an external window that is served outside the block.

Writes are acknowledged in the cycle they are presented. Reads return data, a done flag and an error flag. These read outputs come either in the same cycle or one cycle later, chosen by a retiming parameter.

Two independent parameters enable error reporting. One flags addresses that hit no target. The other flags accesses in the wrong direction to a read-only or write-only target. Strobes are always qualified by direction, so no wrong-direction or unmapped access can change stored state, whether or not reporting is enabled. A protocol bridge placed in front maps the error flags onto its own slave-error response.

Top module: `regdec_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the control, command and wide registers clear to 0 and, with the request idle, `rd_done`, `rd_err` and `rd_data` are 0.
- R2: With the default map, byte address 0x00 selects the read/write control word. An access hits it only when `req` is high and the address equals 0x00 exactly. A write there stores `wr_data` at the next edge, and a read returns the stored value. At most one target strobe is active in a cycle.
- R3: Address 0x04 is read-only. A read returns the parameter `RO_VALUE` (default 0x5EC0_0A17). A write there changes no state, and it raises the error when the direction check is enabled.
- R4: Address 0x08 is write-only. A write stores `wr_data` into the command register, visible on `cmd_q`. A read returns 0 with `rd_done` high, and it raises the error when the direction check is enabled.
- R5: Any access in either direction to the control word or to a wide subword never raises the direction error.
- R6: The error is `req AND (NOT addr_ok OR dir_bad)`. `addr_ok` is true when the unmapped check (`CHK_ADDR`) is off or when any target or the external window is hit. `dir_bad` counts only when `CHK_DIR` is on.
- R7: The 64-bit wide register is split into 32-bit subwords at 0x10 (bits 31:0) and 0x14 (bits 63:32). Each subword is written and read on its own. The addresses 0x11 to 0x13 and 0x18 are unmapped.
- R8: The external window covers 0x80 to 0xBF inclusive and is read-only. A read inside it raises `ext_req` and leaves `rd_done` low. A write inside it raises no `ext_req` and is a direction error. Addresses 0x7C and 0xC0 are outside the window.
- R9: `wr_ack` equals `req AND req_is_wr` in the same cycle. `wr_err` equals the decoded error of R6 when either check is enabled, and is 0 when both are off.
- R10: With `RETIME` = 0, `rd_done` = `req AND NOT req_is_wr AND NOT ext_req` and `rd_err` = decoded error, both in the same cycle. With `RETIME` = 1, `rd_done`, `rd_data` and `rd_err` show those values one clock later.
- R11: An access that raises the error stores nothing, and a read that raises the error returns `rd_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request valid this cycle |
| req_is_wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address |
| wr_data | input | DATA_W | Write data |
| wr_ack | output | 1 | Write acknowledge |
| wr_err | output | 1 | Write error response |
| rd_done | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |
| rd_err | output | 1 | Read error response |
| ext_req | output | 1 | Access routed to the external window |
| ctrl_q | output | DATA_W | Control register contents |
| cmd_q | output | DATA_W | Command (write-only) register contents |
| wide_q | output | WIDE_W | Wide register contents |

## Verification
A wrong address match or a wrong direction qualification corrupts a stored register. That corruption appears on `ctrl_q`, `cmd_q` or `wide_q` at the first clock edge after the faulty access. A misclassified access shows up on `wr_err`, `rd_err` or `ext_req` in the same cycle, or one cycle later on the retimed read path. The bench drives the same stimulus into all four combinations of the two check enables, and it alternates retiming between them. Every output is compared against a behavioural model on every clock, so a fault is reported in the cycle where it first reaches a port.

// File: rtl/regdec_pkg.sv
// Shared map defaults and strobe index layout for the register decoder.
// Assumes byte addressing and one access width equal to the data width.
package regdec_pkg;
    localparam int DEF_ADDR_W    = 8;
    localparam int DEF_DATA_W    = 32;
    localparam int DEF_WIDE_W    = 64;
    localparam int DEF_CTRL_ADDR = 'h00;
    localparam int DEF_RO_ADDR   = 'h04;
    localparam int DEF_WO_ADDR   = 'h08;
    localparam int DEF_WIDE_ADDR = 'h10;
    localparam int DEF_EXT_BASE  = 'h80;
    localparam int DEF_EXT_SIZE  = 64;

    // Strobe vector layout: fixed targets first, wide subwords, then external.
    localparam int IDX_CTRL = 0;
    localparam int IDX_RO   = 1;
    localparam int IDX_WO   = 2;
    localparam int IDX_WIDE = 3;
endpackage

// File: rtl/regdec_decode.sv
// Address decoder: turns one request into direction-qualified strobes and an
// error flag. Purely combinational; assumes the address is stable while req is high.
module regdec_decode
    import regdec_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int DATA_W    = DEF_DATA_W,
    parameter int WIDE_W    = DEF_WIDE_W,
    parameter int CTRL_ADDR = DEF_CTRL_ADDR,
    parameter int RO_ADDR   = DEF_RO_ADDR,
    parameter int WO_ADDR   = DEF_WO_ADDR,
    parameter int WIDE_ADDR = DEF_WIDE_ADDR,
    parameter int EXT_BASE  = DEF_EXT_BASE,
    parameter int EXT_SIZE  = DEF_EXT_SIZE,
    parameter bit EXT_RD    = 1'b1,
    parameter bit EXT_WR    = 1'b0,
    parameter bit CHK_ADDR  = 1'b1,
    parameter bit CHK_DIR   = 1'b1,
    localparam int NSUB     = WIDE_W / DATA_W,
    localparam int NSTRB    = IDX_WIDE + NSUB + 1
) (
    input  logic              req,
    input  logic              is_wr,
    input  logic [ADDR_W-1:0] addr,
    output logic [NSTRB-1:0]  strb,
    output logic              err
);
    localparam int STRIDE  = DATA_W / 8;
    localparam int EXT_IDX = IDX_WIDE + NSUB;

    logic [NSUB-1:0] wide_hit;

    // One exact-match comparator per wide subword.
    for (genvar i = 0; i < NSUB; i++) begin : g_sub
        assign wide_hit[i] = req && (int'(addr) == WIDE_ADDR + i * STRIDE);
    end

    // Match fixed targets and the window, qualify by direction, form the error.
    always_comb begin
        logic hit_ctrl, hit_ro, hit_wo, hit_ext, ext_ok, addr_ok, dir_bad;
        hit_ctrl = req && (int'(addr) == CTRL_ADDR);
        hit_ro   = req && (int'(addr) == RO_ADDR);
        hit_wo   = req && (int'(addr) == WO_ADDR);
        hit_ext  = req && (int'(addr) >= EXT_BASE) && (int'(addr) <= EXT_BASE + EXT_SIZE - 1);
        ext_ok   = is_wr ? EXT_WR : EXT_RD;
        strb           = '0;
        strb[IDX_CTRL] = hit_ctrl;
        strb[IDX_RO]   = hit_ro & ~is_wr;
        strb[IDX_WO]   = hit_wo & is_wr;
        strb[IDX_WIDE +: NSUB] = wide_hit;
        strb[EXT_IDX]  = hit_ext & ext_ok;
        addr_ok = !CHK_ADDR | hit_ctrl | hit_ro | hit_wo | (|wide_hit) | hit_ext;
        dir_bad = (hit_ro & is_wr) | (hit_wo & ~is_wr) | (hit_ext & ~ext_ok);
        err     = req & (~addr_ok | (CHK_DIR & dir_bad));
    end
endmodule

// File: rtl/regdec_store.sv
// Register storage for the software-writable targets. Assumes the write
// enables arrive already qualified by direction and address.
module regdec_store #(
    parameter int DATA_W = 32,
    parameter int WIDE_W = 64,
    localparam int NSUB  = WIDE_W / DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              cmd_we,
    input  logic [NSUB-1:0]   wide_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] cmd_q,
    output logic [WIDE_W-1:0] wide_q
);
    // Control word update.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= wdata;
    end

    // Command word update.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= '0;
        else if (cmd_we) cmd_q <= wdata;
    end

    for (genvar i = 0; i < NSUB; i++) begin : g_wide
        // Per-subword update of the wide register.
        always_ff @(posedge clk) begin
            if (!rst_n)          wide_q[i*DATA_W +: DATA_W] <= '0;
            else if (wide_we[i]) wide_q[i*DATA_W +: DATA_W] <= wdata;
        end
    end
endmodule

// File: rtl/regdec_readback.sv
// Read-data multiplexer with an optional one-cycle retiming stage.
// Assumes the read selects are one-hot or zero.
module regdec_readback #(
    parameter int          DATA_W   = 32,
    parameter int          WIDE_W   = 64,
    parameter logic [31:0] RO_VALUE = 32'h5EC0_0A17,
    parameter bit          RETIME   = 1'b0,
    localparam int         NSUB     = WIDE_W / DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              is_wr,
    input  logic              ext_sel,
    input  logic              err,
    input  logic              sel_ctrl,
    input  logic              sel_ro,
    input  logic [NSUB-1:0]   sel_wide,
    input  logic [DATA_W-1:0] ctrl_q,
    input  logic [WIDE_W-1:0] wide_q,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err
);
    logic [DATA_W-1:0] data_c;
    logic              done_c;

    // OR together the selected sources; an erroring or write access returns 0.
    always_comb begin
        data_c = '0;
        if (!is_wr && !err) begin
            if (sel_ctrl) data_c |= ctrl_q;
            if (sel_ro)   data_c |= DATA_W'(RO_VALUE);
            for (int i = 0; i < NSUB; i++)
                if (sel_wide[i]) data_c |= wide_q[i*DATA_W +: DATA_W];
        end
        done_c = req & ~is_wr & ~ext_sel;
    end

    if (RETIME) begin : g_retime
        // Register done, data and error together.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_done <= 1'b0;
                rd_data <= '0;
                rd_err  <= 1'b0;
            end else begin
                rd_done <= done_c;
                rd_data <= data_c;
                rd_err  <= err;
            end
        end

        // R10
        late_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_done |-> $past(req && !is_wr));
    end else begin : g_direct
        assign rd_done = done_c;
        assign rd_data = data_c;
        assign rd_err  = err;
    end
endmodule

// File: rtl/regdec_top.sv
// Register address decoder top: decode, storage and readback, plus the write
// handshake. Assumes one request per cycle from a protocol front end.
module regdec_top
    import regdec_pkg::*;
#(
    parameter int          ADDR_W    = DEF_ADDR_W,
    parameter int          DATA_W    = DEF_DATA_W,
    parameter int          WIDE_W    = DEF_WIDE_W,
    parameter int          CTRL_ADDR = DEF_CTRL_ADDR,
    parameter int          RO_ADDR   = DEF_RO_ADDR,
    parameter int          WO_ADDR   = DEF_WO_ADDR,
    parameter int          WIDE_ADDR = DEF_WIDE_ADDR,
    parameter int          EXT_BASE  = DEF_EXT_BASE,
    parameter int          EXT_SIZE  = DEF_EXT_SIZE,
    parameter bit          EXT_RD    = 1'b1,
    parameter bit          EXT_WR    = 1'b0,
    parameter logic [31:0] RO_VALUE  = 32'h5EC0_0A17,
    parameter bit          CHK_ADDR  = 1'b1,
    parameter bit          CHK_DIR   = 1'b1,
    parameter bit          RETIME    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_is_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ack,
    output logic              wr_err,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err,
    output logic              ext_req,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] cmd_q,
    output logic [WIDE_W-1:0] wide_q
);
    localparam int NSUB    = WIDE_W / DATA_W;
    localparam int NSTRB   = IDX_WIDE + NSUB + 1;
    localparam int EXT_IDX = IDX_WIDE + NSUB;

    logic [NSTRB-1:0] strb;
    logic             err;

    regdec_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIDE_W(WIDE_W),
        .CTRL_ADDR(CTRL_ADDR), .RO_ADDR(RO_ADDR), .WO_ADDR(WO_ADDR),
        .WIDE_ADDR(WIDE_ADDR), .EXT_BASE(EXT_BASE), .EXT_SIZE(EXT_SIZE),
        .EXT_RD(EXT_RD), .EXT_WR(EXT_WR), .CHK_ADDR(CHK_ADDR), .CHK_DIR(CHK_DIR)
    ) u_decode (
        .req(req), .is_wr(req_is_wr), .addr(addr), .strb(strb), .err(err)
    );

    regdec_store #(.DATA_W(DATA_W), .WIDE_W(WIDE_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(strb[IDX_CTRL] & req_is_wr),
        .cmd_we(strb[IDX_WO]),
        .wide_we(strb[IDX_WIDE +: NSUB] & {NSUB{req_is_wr}}),
        .wdata(wr_data), .ctrl_q(ctrl_q), .cmd_q(cmd_q), .wide_q(wide_q)
    );

    regdec_readback #(
        .DATA_W(DATA_W), .WIDE_W(WIDE_W), .RO_VALUE(RO_VALUE), .RETIME(RETIME)
    ) u_readback (
        .clk(clk), .rst_n(rst_n), .req(req), .is_wr(req_is_wr),
        .ext_sel(strb[EXT_IDX]), .err(err),
        .sel_ctrl(strb[IDX_CTRL]), .sel_ro(strb[IDX_RO]),
        .sel_wide(strb[IDX_WIDE +: NSUB]),
        .ctrl_q(ctrl_q), .wide_q(wide_q),
        .rd_done(rd_done), .rd_data(rd_data), .rd_err(rd_err)
    );

    // Write handshake and external routing.
    assign wr_ack  = req & req_is_wr;
    assign wr_err  = (CHK_ADDR || CHK_DIR) ? err : 1'b0;
    assign ext_req = strb[EXT_IDX];

    // R2
    strb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strb));
    // R9
    wr_err_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> req);
    // R11
    err_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && req_is_wr) |=> ($stable(ctrl_q) && $stable(cmd_q) && $stable(wide_q)));
    // R8
    ext_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |-> (req && !req_is_wr && !wr_ack));
endmodule

// File: tb/test_regdec_top.sv
`timescale 1ns/1ps
// Bench: four decoder copies covering every pair of check enables, driven
// together and compared each clock against a behavioural model.
module test_regdec_top;
    localparam logic [31:0] ROV = 32'h5EC0_0A17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, req_is_wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wr_data = '0;

    logic [3:0]  wr_ack_v, wr_err_v, rd_done_v, rd_err_v, ext_req_v;
    logic [31:0] rd_data_v [4];
    logic [31:0] ctrl_v [4];
    logic [31:0] cmd_v [4];
    logic [63:0] wide_v [4];

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    for (genvar g = 0; g < 4; g++) begin : g_cfg
        regdec_top #(
            .CHK_ADDR(g[0]), .CHK_DIR(g[1]), .RETIME(g[0] ^ g[1])
        ) i_regdec_top (
            .clk(clk), .rst_n(rst_n), .req(req), .req_is_wr(req_is_wr),
            .addr(addr), .wr_data(wr_data),
            .wr_ack(wr_ack_v[g]), .wr_err(wr_err_v[g]),
            .rd_done(rd_done_v[g]), .rd_data(rd_data_v[g]), .rd_err(rd_err_v[g]),
            .ext_req(ext_req_v[g]), .ctrl_q(ctrl_v[g]), .cmd_q(cmd_v[g]),
            .wide_q(wide_v[g])
        );
    end

    // Model state
    logic [31:0] m_ctrl = '0, m_cmd = '0;
    logic [63:0] m_wide = '0;
    logic        p_done [4] = '{default: 1'b0};
    logic        p_err  [4] = '{default: 1'b0};
    logic [31:0] p_data [4] = '{default: 32'h0};

    task automatic chk(input string r, input int c, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cfg%0d addr=%h wr=%b actual=%h expected=%h", r, c, addr, req_is_wr, act, exp);
        end
    endtask

    // 0 ctrl, 1 ro, 2 cmd, 3 wide lo, 4 wide hi, 5 external, 6 unmapped
    function automatic int kind(input logic [7:0] a);
        if (a == 8'h00) return 0;
        if (a == 8'h04) return 1;
        if (a == 8'h08) return 2;
        if (a == 8'h10) return 3;
        if (a == 8'h14) return 4;
        if (a >= 8'h80 && a <= 8'hBF) return 5;
        return 6;
    endfunction

    // Compare all outputs of every copy with the model, then advance the model.
    task automatic evaluate();
        int k = kind(addr);
        for (int c = 0; c < 4; c++) begin
            bit ca = c[0], cd = c[1], rt = c[0] ^ c[1];
            bit valid = !ca || (k != 6);
            bit bad = cd && ((k == 1 && req_is_wr) || (k == 2 && !req_is_wr) || (k == 5 && req_is_wr));
            bit err = req && (!valid || bad);
            bit ext = req && k == 5 && !req_is_wr;
            bit done = req && !req_is_wr && !ext;
            logic [31:0] data = '0;
            if (req && !req_is_wr && !err) begin
                case (k)
                    0: data = m_ctrl;
                    1: data = ROV;
                    3: data = m_wide[31:0];
                    4: data = m_wide[63:32];
                    default: data = '0;
                endcase
            end
            chk("R9 wr_ack", c, 64'(wr_ack_v[c]), 64'(req && req_is_wr));
            chk("R6 R9 wr_err", c, 64'(wr_err_v[c]), 64'((ca || cd) ? err : 1'b0));
            chk("R8 ext_req", c, 64'(ext_req_v[c]), 64'(ext));
            chk("R2 R7 ctrl_q", c, 64'(ctrl_v[c]), 64'(m_ctrl));
            chk("R4 R11 cmd_q", c, 64'(cmd_v[c]), 64'(m_cmd));
            chk("R7 R11 wide_q", c, wide_v[c], m_wide);
            if (rt) begin
                chk("R10 rd_done retimed", c, 64'(rd_done_v[c]), 64'(p_done[c]));
                chk("R3 R10 rd_data retimed", c, 64'(rd_data_v[c]), 64'(p_data[c]));
                chk("R6 R10 rd_err retimed", c, 64'(rd_err_v[c]), 64'(p_err[c]));
            end else begin
                chk("R10 rd_done", c, 64'(rd_done_v[c]), 64'(done));
                chk("R3 R11 rd_data", c, 64'(rd_data_v[c]), 64'(data));
                chk("R6 R5 rd_err", c, 64'(rd_err_v[c]), 64'(err));
            end
            p_done[c] = done;
            p_data[c] = data;
            p_err[c]  = err;
        end
        if (req && req_is_wr) begin
            case (k)
                0: m_ctrl = wr_data;
                2: m_cmd = wr_data;
                3: m_wide[31:0] = wr_data;
                4: m_wide[63:32] = wr_data;
                default: ;
            endcase
        end
    endtask

    task automatic access(input logic v, input logic w, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req = v; req_is_wr = w; addr = a; wr_data = d;
        #1;
        evaluate();
    endtask

    // Watchdog
    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        logic [7:0] pool [12] = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h80,
                                  8'hBF, 8'h90, 8'hC0, 8'h7C, 8'h02, 8'h18};
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        for (int c = 0; c < 4; c++) begin
            chk("R1 rd_done", c, 64'(rd_done_v[c]), 64'h0);
            chk("R1 rd_err", c, 64'(rd_err_v[c]), 64'h0);
            chk("R1 rd_data", c, 64'(rd_data_v[c]), 64'h0);
            chk("R1 ctrl_q", c, 64'(ctrl_v[c]), 64'h0);
            chk("R1 cmd_q", c, 64'(cmd_v[c]), 64'h0);
            chk("R1 wide_q", c, wide_v[c], 64'h0);
        end
        rst_n = 1'b1;
        // R2 R5: control word
        access(1, 1, 8'h00, 32'h1234_5678);
        access(1, 0, 8'h00, 32'h0);
        // R4: write-only command
        access(1, 1, 8'h08, 32'hCAFE_F00D);
        access(1, 0, 8'h08, 32'h0);
        // R3: read-only identity
        access(1, 0, 8'h04, 32'h0);
        access(1, 1, 8'h04, 32'hDEAD_BEEF);
        // R7: wide subwords and near misses
        access(1, 1, 8'h10, 32'hAAAA_0001);
        access(1, 1, 8'h14, 32'hBBBB_0002);
        access(1, 0, 8'h14, 32'h0);
        access(1, 0, 8'h10, 32'h0);
        access(1, 1, 8'h11, 32'h0BAD_0BAD);
        access(1, 0, 8'h18, 32'h0);
        // R8: external window edges
        access(1, 0, 8'h80, 32'h0);
        access(1, 0, 8'hBF, 32'h0);
        access(1, 1, 8'h90, 32'h1111_1111);
        access(1, 0, 8'hC0, 32'h0);
        access(1, 0, 8'h7C, 32'h0);
        // R11 R6: unmapped write and idle cycles
        access(1, 1, 8'h02, 32'h7777_7777);
        access(0, 1, 8'h00, 32'hFFFF_FFFF);
        access(0, 0, 8'h20, 32'h0);
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            access(lfsr[0] | lfsr[1], lfsr[2], pool[int'(lfsr[11:8]) % 12], {lfsr, ~lfsr});
        end
        access(0, 0, 8'h00, 32'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule